// File: doc/BRIEF.md
# One-Bit Logic Unit with Result Register

This block is the logic core of a one-bit control processor. It keeps a single result bit and, on each execute step, replaces it with a function of its current value and one data bit. The data bit comes from the processor's input or scratchpad path, and it is already forced to 0 when input is disabled.

The lower eight opcodes choose among hold, load, AND, OR and XNOR, with true or complemented data for load, AND and OR. The upper eight opcodes are store and control instructions. For these the selection is gated to the identity, so they never disturb the result. The block also drives the value to be stored. This is the result as it stands, or its inverse for the complemented-store opcode.

The surrounding processor supplies the opcode nibble and the data bit. It pulses `exec_en` on the clock edge that closes each execute phase.

Top module: `lu_top`

## Requirements
- R1: An active-low `rst_n` clears `result` to 0 asynchronously, and it stays 0 while reset is held.
- R2: Opcode 4'h0 leaves `result` unchanged on an execute step.
- R3: Opcode 4'h1 sets `result` to `data_in`, and opcode 4'h2 sets it to the inverse of `data_in`.
- R4: Opcode 4'h3 sets `result` to `result AND data_in`, and opcode 4'h4 sets it to `result AND NOT data_in`.
- R5: Opcode 4'h5 sets `result` to `result OR data_in`, and opcode 4'h6 sets it to `result OR NOT data_in`.
- R6: Opcode 4'h7 sets `result` to `NOT (result XOR data_in)`.
- R7: Any opcode with bit 3 set (4'h8 to 4'hF) leaves `result` unchanged, whatever `data_in` is.
- R8: `data_out` combinationally equals the inverse of `result` when the opcode is 4'h9, and equals `result` for every other opcode.
- R9: `result` changes only on a rising `clk` edge where `exec_en` is 1, and the new value is visible right after that edge. With `exec_en` at 0, no opcode or data has any effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec_en | input | 1 | Marks the edge that ends an execute phase |
| opcode | input | 4 | Instruction nibble |
| data_in | input | 1 | Data bit, already gated by input enable |
| result | output | 1 | Result register |
| data_out | output | 1 | Value to store: result, or its inverse for opcode 9 |

## Verification
The hardest case to show is that an upper opcode truly holds the register. A load-like opcode that happens to rewrite the same value would hide a failure. The stimulus therefore arranges that every upper opcode is applied with `data_in` opposite to the current result, and with the result at both 0 and 1. This way any leak of the data bit into the register changes the output. Execute steps with `exec_en` low get the same treatment, using load and complement-load opcodes whose data would flip the result.

// File: rtl/lu_pkg.sv
package lu_pkg;
    localparam int OP_W  = 4;
    localparam int SEL_W = OP_W - 1;
    localparam int N_OPS = 1 << SEL_W;

    typedef enum logic [SEL_W-1:0] {
        LU_HOLD  = 3'd0,
        LU_LOAD  = 3'd1,
        LU_LOADN = 3'd2,
        LU_AND   = 3'd3,
        LU_ANDN  = 3'd4,
        LU_OR    = 3'd5,
        LU_ORN   = 3'd6,
        LU_XNOR  = 3'd7
    } lu_op_e;

    typedef struct packed {
        logic rr;
    } lu_state_t;

    localparam logic [OP_W-1:0] OPC_STORE_INV = OP_W'(N_OPS + 1);
endpackage

// File: rtl/lu_op_decode.sv
module lu_op_decode
    import lu_pkg::*;
(
    input  logic [OP_W-1:0] opcode,
    output lu_op_e          op_sel,
    output logic            store_inv
);
    always_comb begin
        if (opcode[OP_W-1]) begin
            op_sel = LU_HOLD;
        end else begin
            op_sel = lu_op_e'(opcode[SEL_W-1:0]);
        end
        store_inv = (opcode == OPC_STORE_INV);
    end
endmodule

// File: rtl/lu_operand.sv
module lu_operand
    import lu_pkg::*;
(
    input  lu_op_e op_sel,
    input  logic   data_in,
    output logic   operand
);
    logic invert;

    always_comb begin
        unique case (op_sel)
            LU_LOADN, LU_ANDN, LU_ORN: invert = 1'b1;
            default:                   invert = 1'b0;
        endcase
        operand = data_in ^ invert;
    end
endmodule

// File: rtl/lu_next_mux.sv
module lu_next_mux
    import lu_pkg::*;
(
    input  lu_op_e op_sel,
    input  logic   rr_cur,
    input  logic   operand,
    input  logic   data_raw,
    output logic   rr_next
);
    logic [N_OPS-1:0] cand;

    for (genvar i = 0; i < N_OPS; i++) begin : g_cand
        if (i == int'(LU_HOLD)) begin : g_hold
            assign cand[i] = rr_cur;
        end else if (i == int'(LU_LOAD) || i == int'(LU_LOADN)) begin : g_load
            assign cand[i] = operand;
        end else if (i == int'(LU_AND) || i == int'(LU_ANDN)) begin : g_and
            assign cand[i] = rr_cur & operand;
        end else if (i == int'(LU_OR) || i == int'(LU_ORN)) begin : g_or
            assign cand[i] = rr_cur | operand;
        end else begin : g_xnor
            assign cand[i] = ~(rr_cur ^ data_raw);
        end
    end

    assign rr_next = cand[op_sel];
endmodule

// File: rtl/lu_top.sv
module lu_top
    import lu_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            exec_en,
    input  logic [OP_W-1:0] opcode,
    input  logic            data_in,
    output logic            result,
    output logic            data_out
);
    lu_op_e    op_sel;
    logic      store_inv;
    logic      operand;
    logic      rr_next;
    lu_state_t st_d;
    lu_state_t st_q;

    lu_op_decode u_dec (
        .opcode    (opcode),
        .op_sel    (op_sel),
        .store_inv (store_inv)
    );

    lu_operand u_opnd (
        .op_sel  (op_sel),
        .data_in (data_in),
        .operand (operand)
    );

    lu_next_mux u_mux (
        .op_sel   (op_sel),
        .rr_cur   (st_q.rr),
        .operand  (operand),
        .data_raw (data_in),
        .rr_next  (rr_next)
    );

    always_comb begin
        st_d = st_q;
        if (exec_en) begin
            st_d.rr = rr_next;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result   = st_q.rr;
    assign data_out = st_q.rr ^ store_inv;
endmodule

// File: rtl/lu_checker.sv
module lu_checker
    import lu_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            exec_en,
    input logic [OP_W-1:0] opcode,
    input logic            data_in,
    input logic            result,
    input logic            data_out
);
    a_r1_reset_clear: assert property (@(posedge clk) !rst_n |-> result == 1'b0)
        else $error("a_r1_reset_clear");

    a_r2_nop_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && opcode == 4'h0) |=> $stable(result))
        else $error("a_r2_nop_hold");

    a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && opcode == 4'h1) |=> result == $past(data_in))
        else $error("a_r3_load");

    a_r4_andc: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && opcode == 4'h4) |=> result == ($past(result) & ~$past(data_in)))
        else $error("a_r4_andc");

    a_r5_or: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && opcode == 4'h5) |=> result == ($past(result) | $past(data_in)))
        else $error("a_r5_or");

    a_r6_xnor: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && opcode == 4'h7) |=> result == ~($past(result) ^ $past(data_in)))
        else $error("a_r6_xnor");

    a_r7_upper_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && opcode[3]) |=> $stable(result))
        else $error("a_r7_upper_hold");

    a_r8_store_value: assert property (@(posedge clk) disable iff (!rst_n)
        data_out == ((opcode == 4'h9) ? ~result : result))
        else $error("a_r8_store_value");

    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_en |=> $stable(result))
        else $error("a_r9_idle_hold");
endmodule

bind lu_top lu_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .exec_en  (exec_en),
    .opcode   (opcode),
    .data_in  (data_in),
    .result   (result),
    .data_out (data_out)
);

// File: tb/tb_lu_top.sv
`timescale 1ns/1ps
module tb_lu_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       exec_en = 1'b0;
    logic [3:0] opcode = 4'h0;
    logic       data_in = 1'b0;
    logic       result;
    logic       data_out;

    int checks = 0;
    int failures = 0;
    logic model_rr = 1'b0;

    typedef struct {
        logic  exp;
        string tag;
    } sb_item_t;
    sb_item_t sb_q[$];

    always #10 clk = ~clk;

    lu_top dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .exec_en  (exec_en),
        .opcode   (opcode),
        .data_in  (data_in),
        .result   (result),
        .data_out (data_out)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    function automatic logic model_next(input logic [3:0] op, input logic rr, input logic d);
        if (op[3]) return rr;
        case (op[2:0])
            3'd0: return rr;
            3'd1: return d;
            3'd2: return ~d;
            3'd3: return rr & d;
            3'd4: return rr & ~d;
            3'd5: return rr | d;
            3'd6: return rr | ~d;
            default: return ~(rr ^ d);
        endcase
    endfunction

    // driver: applies one step and queues the expected result after the edge
    task automatic step(input logic [3:0] op, input logic d, input logic en, input string tag);
        @(negedge clk);
        opcode  = op;
        data_in = d;
        exec_en = en;
        #1;
        check("R8 data_out", data_out, (op == 4'h9) ? ~model_rr : model_rr);
        if (en) model_rr = model_next(op, model_rr, d);
        sb_q.push_back('{exp: model_rr, tag: tag});
    endtask

    // monitor: compares the register shortly after each rising edge
    always @(posedge clk) begin
        #5;
        if (rst_n && sb_q.size() > 0) begin
            sb_item_t it;
            it = sb_q.pop_front();
            check(it.tag, result, it.exp);
        end
    end

    initial begin
        #4000000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset value", result, 1'b0);
        rst_n = 1'b1;
        model_rr = 1'b0;

        step(4'h1, 1'b1, 1'b1, "R3 load 1");
        step(4'h0, 1'b0, 1'b1, "R2 nop hold 1");
        step(4'h2, 1'b1, 1'b1, "R3 loadc to 0");
        step(4'h0, 1'b1, 1'b1, "R2 nop hold 0");
        step(4'h2, 1'b0, 1'b1, "R3 loadc to 1");
        step(4'h3, 1'b1, 1'b1, "R4 and keep 1");
        step(4'h3, 1'b0, 1'b1, "R4 and to 0");
        step(4'h1, 1'b1, 1'b1, "R3 load 1");
        step(4'h4, 1'b0, 1'b1, "R4 andc keep 1");
        step(4'h4, 1'b1, 1'b1, "R4 andc to 0");
        step(4'h5, 1'b0, 1'b1, "R5 or keep 0");
        step(4'h5, 1'b1, 1'b1, "R5 or to 1");
        step(4'h2, 1'b1, 1'b1, "R3 loadc 0");
        step(4'h6, 1'b1, 1'b1, "R5 orc keep 0");
        step(4'h6, 1'b0, 1'b1, "R5 orc to 1");
        step(4'h7, 1'b1, 1'b1, "R6 xnor 1,1");
        step(4'h7, 1'b0, 1'b1, "R6 xnor 1,0");
        step(4'h7, 1'b0, 1'b1, "R6 xnor 0,0");
        step(4'h7, 1'b1, 1'b1, "R6 xnor 1,1 again");

        // upper opcodes with data opposite to result, at both result values
        for (int v = 0; v < 2; v++) begin
            step(4'h1, v[0], 1'b1, "R3 set level");
            for (int op = 8; op < 16; op++) begin
                step(op[3:0], ~v[0], 1'b1, "R7 upper opcode hold");
            end
        end

        // execute enable low: nothing may change
        step(4'h1, 1'b0, 1'b1, "R3 load 0");
        step(4'h1, 1'b1, 1'b0, "R9 idle load");
        step(4'h2, 1'b0, 1'b0, "R9 idle loadc");
        step(4'h6, 1'b0, 1'b0, "R9 idle orc");
        step(4'h1, 1'b1, 1'b1, "R9 enabled load");
        step(4'h9, 1'b0, 1'b1, "R8 stoc cycle hold");
        step(4'h8, 1'b0, 1'b1, "R8 sto cycle hold");

        // asynchronous reset mid-run
        @(negedge clk);
        #3;
        rst_n = 1'b0;
        #1;
        check("R1 async clear", result, 1'b0);
        @(negedge clk);
        exec_en = 1'b1; opcode = 4'h1; data_in = 1'b1;
        @(posedge clk);
        #2;
        check("R1 held in reset", result, 1'b0);
        @(negedge clk);
        exec_en = 1'b0;
        sb_q.delete();
        rst_n = 1'b1;
        model_rr = 1'b0;
        step(4'h0, 1'b1, 1'b1, "R1 hold after reset");
        step(4'h6, 1'b0, 1'b1, "R5 orc after reset");

        @(negedge clk);
        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule